// File: doc/BRIEF.md
# Butterfly Multistage Switching Network with Relative-Address Steering

This block moves one set of packets per clock from N source ports to N destination ports through a butterfly of 2x2 switching elements. There are log2 N stages, each with N/2 elements, so the network holds (N/2)·log2 N elements in total. Each source port offers a valid bit, a destination port number and a payload. The steering tag of a packet is the exclusive-or of its source and destination numbers. In stage i a packet keeps its row when bit i of that tag is 0 (straight edge). When the bit is 1 it moves to the row whose index differs in bit i (cross edge). Every source-destination pair has exactly one path, and every packet crosses all stages.

Each stage ends in a register, so the network accepts a new set of packets in every cycle. The network has no buffers. When two packets in one element ask for the same output, the packet from the upper row (bit i of the row index clear) goes on. The other packet is discarded, and the drop flag of its source port rises in the same cycle in which the packet would otherwise have come out.

Top module: `bfly_net`

## Requirements
- R1: While reset is held and in the first cycle after it, every out_vld and drop_flag bit is 0.
- R2: A packet that is not discarded, presented on source port s in cycle c, appears with out_vld set on port in_dst[s] in cycle c+NLOG. A new set of packets may be presented in every cycle.
- R3: A delivered packet carries its payload unchanged on out_dat, and its source port number on out_src.
- R4: In stage i (i = 0 first), an element pairs the rows whose indices differ only in bit i. A packet goes straight when bit i of (source xor destination) is 0 and crosses to row index xor 2^i when that bit is 1.
- R5: When two valid packets in one element want the same output, the packet from the row with bit i clear wins.
- R6: A losing packet appears on no output port. drop_flag[s], indexed by source port s, is 1 in exactly the cycle c+NLOG in which that packet would have been delivered.
- R7: When every source uses the same tag (destination = source xor K), no element sees a conflict, so all N packets are delivered and no drop flag rises.
- R8: A source port with in_vld at 0 yields no output and no drop flag, whatever its in_dst and in_dat hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | N | Packet present, one bit per source port |
| in_dst | input | N x NLOG | Destination port number per source port |
| in_dat | input | N x DW | Payload per source port |
| out_vld | output | N | Packet delivered, one bit per destination port |
| out_src | output | N x NLOG | Source port number of the delivered packet |
| out_dat | output | N x DW | Payload of the delivered packet |
| drop_flag | output | N | Packet discarded, one bit per source port |

## Verification
The bench builds a pair of packets that collide on the first-stage link. A network that favours the lower row would then deliver the wrong packet and flag the wrong source. Sets where every source uses the same xor tag must pass with no drops. A design that compared destination bits instead of tag bits would flag drops there or send packets to the wrong port. Idle sources carry random destinations and payloads, which exposes a network that lets a stale or invalid entry claim a link or raise a flag. Random permutations and partial random traffic run back to back and are checked against a link-by-link collision model. A flag off by one cycle or attached to the wrong source is caught, and so is a packet dropped without a real conflict.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Relative address: bit i selects the edge taken in stage i.
  function automatic int unsigned route_tag(int unsigned src, int unsigned dst);
    return src ^ dst;
  endfunction

  // 1 when the packet takes the cross edge in stage stg.
  function automatic logic steer_cross(int unsigned tag, int unsigned stg);
    return logic'((tag >> stg) & 1);
  endfunction

  // Upper packet heads to port up_cross, lower packet heads to port !dn_cross;
  // they meet on one port exactly when the two steering bits differ.
  function automatic logic lanes_clash(logic up_cross, logic dn_cross);
    return up_cross ^ dn_cross;
  endfunction

endpackage

// File: rtl/bfly_switch.sv
module bfly_switch #(
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int STG = 0
) (
  input  logic          up_vld,
  input  logic [AW-1:0] up_src,
  input  logic [AW-1:0] up_dst,
  input  logic [DW-1:0] up_dat,
  input  logic          dn_vld,
  input  logic [AW-1:0] dn_src,
  input  logic [AW-1:0] dn_dst,
  input  logic [DW-1:0] dn_dat,
  output logic          p0_vld,
  output logic [AW-1:0] p0_src,
  output logic [AW-1:0] p0_dst,
  output logic [DW-1:0] p0_dat,
  output logic          p1_vld,
  output logic [AW-1:0] p1_src,
  output logic [AW-1:0] p1_dst,
  output logic [DW-1:0] p1_dat,
  output logic          up_to_hi,
  output logic          clash,
  output logic          dn_lost
);
  import bfly_pkg::*;

  logic up_x, dn_x, dn_ok, dn_to_hi;

  always_comb begin
    up_x     = steer_cross(route_tag(32'(up_src), 32'(up_dst)), STG);
    dn_x     = steer_cross(route_tag(32'(dn_src), 32'(dn_dst)), STG);
    up_to_hi = up_x;
    dn_to_hi = ~dn_x;
    clash    = up_vld & dn_vld & lanes_clash(up_x, dn_x);
    dn_lost  = clash;
    dn_ok    = dn_vld & ~clash;
  end

  always_comb begin
    p0_vld = 1'b0; p0_src = '0; p0_dst = '0; p0_dat = '0;
    p1_vld = 1'b0; p1_src = '0; p1_dst = '0; p1_dat = '0;
    if (dn_ok && !dn_to_hi) begin
      p0_vld = 1'b1; p0_src = dn_src; p0_dst = dn_dst; p0_dat = dn_dat;
    end
    if (dn_ok && dn_to_hi) begin
      p1_vld = 1'b1; p1_src = dn_src; p1_dst = dn_dst; p1_dat = dn_dat;
    end
    if (up_vld && !up_to_hi) begin
      p0_vld = 1'b1; p0_src = up_src; p0_dst = up_dst; p0_dat = up_dat;
    end
    if (up_vld && up_to_hi) begin
      p1_vld = 1'b1; p1_src = up_src; p1_dst = up_dst; p1_dat = up_dat;
    end
  end

endmodule

// File: rtl/bfly_stage.sv
module bfly_stage #(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int DW  = 16,
  parameter int STG = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           vld_i,
  input  logic [N-1:0][AW-1:0]   src_i,
  input  logic [N-1:0][AW-1:0]   dst_i,
  input  logic [N-1:0][DW-1:0]   dat_i,
  input  logic [N-1:0]           drp_i,
  output logic [N-1:0]           vld_o,
  output logic [N-1:0]           drp_o,
  output logic [N-1:0][AW-1:0]   src_o,
  output logic [N-1:0][AW-1:0]   dst_o,
  output logic [N-1:0][DW-1:0]   dat_o
);
  localparam int NSW = N / 2;
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0]          vld_n;
  logic [N-1:0][AW-1:0]  src_n, dst_n;
  logic [N-1:0][DW-1:0]  dat_n;
  logic [NSW-1:0][N-1:0] lost_mask;
  logic [NSW-1:0]        sw_clash, sw_up_hi;
  logic [N-1:0]          lost_any;

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    localparam int LO = ((k >> STG) << (STG + 1)) | (k & ((1 << STG) - 1));
    localparam int HI = LO + (1 << STG);
    logic dn_lost;

    bfly_switch #(.AW(AW), .DW(DW), .STG(STG)) i_sw (
      .up_vld(vld_i[LO]), .up_src(src_i[LO]), .up_dst(dst_i[LO]), .up_dat(dat_i[LO]),
      .dn_vld(vld_i[HI]), .dn_src(src_i[HI]), .dn_dst(dst_i[HI]), .dn_dat(dat_i[HI]),
      .p0_vld(vld_n[LO]), .p0_src(src_n[LO]), .p0_dst(dst_n[LO]), .p0_dat(dat_n[LO]),
      .p1_vld(vld_n[HI]), .p1_src(src_n[HI]), .p1_dst(dst_n[HI]), .p1_dat(dat_n[HI]),
      .up_to_hi(sw_up_hi[k]), .clash(sw_clash[k]), .dn_lost(dn_lost)
    );

    assign lost_mask[k] = dn_lost ? (ONE << src_i[HI]) : '0;

    // R5
    upper_wins_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clash[k] && !sw_up_hi[k]) |=> (vld_o[LO] && src_o[LO] == $past(src_i[LO])));
    // R5
    upper_wins_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clash[k] && sw_up_hi[k]) |=> (vld_o[HI] && src_o[HI] == $past(src_i[LO])));
  end

  always_comb begin
    lost_any = '0;
    for (int k = 0; k < NSW; k++) lost_any |= lost_mask[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= '0;
      drp_o <= '0;
      src_o <= '0;
      dst_o <= '0;
      dat_o <= '0;
    end else begin
      vld_o <= vld_n;
      drp_o <= drp_i | lost_any;
      src_o <= src_n;
      dst_o <= dst_n;
      dat_o <= dat_n;
    end
  end

  // R6: every packet entering the stage leaves it either live or flagged
  packet_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld_o) + $countones(drp_o)) ==
      $past($countones(vld_i) + $countones(drp_i)));

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int NLOG = 3,
  parameter int DW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [(1<<NLOG)-1:0]       in_vld,
  input  logic [(1<<NLOG)-1:0][NLOG-1:0] in_dst,
  input  logic [(1<<NLOG)-1:0][DW-1:0]   in_dat,
  output logic [(1<<NLOG)-1:0]       out_vld,
  output logic [(1<<NLOG)-1:0][NLOG-1:0] out_src,
  output logic [(1<<NLOG)-1:0][DW-1:0]   out_dat,
  output logic [(1<<NLOG)-1:0]       drop_flag
);
  localparam int N  = 1 << NLOG;
  localparam int AW = NLOG;

  logic [NLOG:0][N-1:0]          b_vld, b_drp;
  logic [NLOG:0][N-1:0][AW-1:0]  b_src, b_dst;
  logic [NLOG:0][N-1:0][DW-1:0]  b_dat;

  always_comb begin
    b_vld[0] = in_vld;
    b_drp[0] = '0;
    b_dst[0] = in_dst;
    b_dat[0] = in_dat;
    for (int s = 0; s < N; s++) b_src[0][s] = AW'(s);
  end

  for (genvar st = 0; st < NLOG; st++) begin : g_stage
    bfly_stage #(.N(N), .AW(AW), .DW(DW), .STG(st)) i_stage (
      .clk(clk), .rst_n(rst_n),
      .vld_i(b_vld[st]), .src_i(b_src[st]), .dst_i(b_dst[st]),
      .dat_i(b_dat[st]), .drp_i(b_drp[st]),
      .vld_o(b_vld[st+1]), .drp_o(b_drp[st+1]), .src_o(b_src[st+1]),
      .dst_o(b_dst[st+1]), .dat_o(b_dat[st+1])
    );
  end

  assign out_vld   = b_vld[NLOG];
  assign out_src   = b_src[NLOG];
  assign out_dat   = b_dat[NLOG];
  assign drop_flag = b_drp[NLOG];

  for (genvar p = 0; p < N; p++) begin : g_chk
    // R4
    arrival_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] |-> (b_dst[NLOG][p] == AW'(p)));
    // R6
    no_deliver_and_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[p] |-> !drop_flag[out_src[p]]);
  end

endmodule

// File: tb/test_bfly_net.sv
module test_bfly_net;
  localparam int NLOG = 3;
  localparam int DW   = 16;
  localparam int N    = 1 << NLOG;
  localparam int AW   = NLOG;
  localparam int RING = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]          in_vld = '0;
  logic [N-1:0][AW-1:0]  in_dst = '0;
  logic [N-1:0][DW-1:0]  in_dat = '0;
  logic [N-1:0]          out_vld;
  logic [N-1:0][AW-1:0]  out_src;
  logic [N-1:0][DW-1:0]  out_dat;
  logic [N-1:0]          drop_flag;

  always #10 clk = ~clk;

  bfly_net #(.NLOG(NLOG), .DW(DW)) i_bfly_net (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dst(in_dst), .in_dat(in_dat),
    .out_vld(out_vld), .out_src(out_src), .out_dat(out_dat), .drop_flag(drop_flag)
  );

  int checks = 0;
  int fails  = 0;
  int tick_n = 0;

  logic [N-1:0]  r_vld [RING];
  logic [N-1:0]  r_drp [RING];
  logic [AW-1:0] r_src [RING][N];
  logic [DW-1:0] r_dat [RING][N];
  string         r_tag [RING];

  logic          s_vld [N];
  logic [AW-1:0] s_dst [N];
  logic [DW-1:0] s_dat [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Link-level model: after stage st a packet sits at row pos ^ (tag bit st) << st;
  // two live packets landing on one row collide, the one from the row with bit st clear survives.
  task automatic model(input int slot, input string tag);
    int  pos [N];
    int  nx  [N];
    bit  alive [N];
    bit  kill  [N];
    for (int s = 0; s < N; s++) begin
      pos[s] = s;
      alive[s] = s_vld[s];
    end
    for (int st = 0; st < NLOG; st++) begin
      for (int s = 0; s < N; s++)
        nx[s] = pos[s] ^ ((((s ^ int'(s_dst[s])) >> st) & 1) << st);
      for (int s = 0; s < N; s++) begin
        kill[s] = 1'b0;
        for (int t = 0; t < N; t++)
          if (alive[s] && alive[t] && s != t && nx[s] == nx[t] && ((pos[s] >> st) & 1) == 1)
            kill[s] = 1'b1;
      end
      for (int s = 0; s < N; s++) begin
        if (kill[s]) alive[s] = 1'b0;
        pos[s] = nx[s];
      end
    end
    r_vld[slot] = '0;
    r_drp[slot] = '0;
    r_tag[slot] = tag;
    for (int p = 0; p < N; p++) begin
      r_src[slot][p] = '0;
      r_dat[slot][p] = '0;
    end
    for (int s = 0; s < N; s++) begin
      if (alive[s]) begin
        r_vld[slot][pos[s]] = 1'b1;
        r_src[slot][pos[s]] = AW'(s);
        r_dat[slot][pos[s]] = s_dat[s];
      end else if (s_vld[s]) begin
        r_drp[slot][s] = 1'b1;
      end
    end
  endtask

  task automatic compare(input int slot);
    string t;
    t = r_tag[slot];
    for (int p = 0; p < N; p++) begin
      chk(out_vld[p] == r_vld[slot][p], {t, " R2 R4 R8"}, $sformatf("out_vld[%0d]", p),
          int'(out_vld[p]), int'(r_vld[slot][p]));
      if (r_vld[slot][p]) begin
        chk(out_src[p] == r_src[slot][p], {t, " R3"}, $sformatf("out_src[%0d]", p),
            int'(out_src[p]), int'(r_src[slot][p]));
        chk(out_dat[p] == r_dat[slot][p], {t, " R3"}, $sformatf("out_dat[%0d]", p),
            int'(out_dat[p]), int'(r_dat[slot][p]));
      end
    end
    for (int s = 0; s < N; s++)
      chk(drop_flag[s] == r_drp[slot][s], {t, " R5 R6"}, $sformatf("drop_flag[%0d]", s),
          int'(drop_flag[s]), int'(r_drp[slot][s]));
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    if (tick_n >= NLOG) compare((tick_n - NLOG) % RING);
    for (int s = 0; s < N; s++) begin
      in_vld[s] = s_vld[s];
      in_dst[s] = s_dst[s];
      in_dat[s] = s_dat[s];
    end
    model(tick_n % RING, tag);
    tick_n++;
  endtask

  task automatic clear_set();
    for (int s = 0; s < N; s++) begin
      s_vld[s] = 1'b0;
      s_dst[s] = '0;
      s_dat[s] = '0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_b17f));
    clear_set();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_vld == '0, "R1", "out_vld in reset", int'(out_vld), 0);
    chk(drop_flag == '0, "R1", "drop_flag in reset", int'(drop_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == '0, "R1", "out_vld after reset", int'(out_vld), 0);
    chk(drop_flag == '0, "R1", "drop_flag after reset", int'(drop_flag), 0);

    // R5: source 0 -> 1 crosses in stage 0, source 1 -> 3 goes straight; both claim row 1
    clear_set();
    s_vld[0] = 1'b1; s_dst[0] = AW'(1); s_dat[0] = 16'hA0A0;
    s_vld[1] = 1'b1; s_dst[1] = AW'(3); s_dat[1] = 16'hB1B1;
    tick("R5");
    clear_set();
    tick("R5");

    // R7: one common tag K for all sources gives no conflict
    for (int k = 0; k < N; k++) begin
      for (int s = 0; s < N; s++) begin
        s_vld[s] = 1'b1;
        s_dst[s] = AW'(s ^ k);
        s_dat[s] = DW'($urandom);
      end
      tick("R7");
    end

    // R8: idle ports with junk destination and payload
    for (int i = 0; i < 4; i++) begin
      for (int s = 0; s < N; s++) begin
        s_vld[s] = 1'b0;
        s_dst[s] = AW'($urandom);
        s_dat[s] = DW'($urandom);
      end
      if (i >= 2) s_vld[i] = 1'b1;
      tick("R8");
    end

    // R2 R4: random full permutations, back to back
    for (int i = 0; i < 150; i++) begin
      for (int s = 0; s < N; s++) s_dst[s] = AW'(s);
      for (int s = N - 1; s > 0; s--) begin
        int j;
        logic [AW-1:0] tmp;
        j = int'($urandom % (s + 1));
        tmp = s_dst[s]; s_dst[s] = s_dst[j]; s_dst[j] = tmp;
      end
      for (int s = 0; s < N; s++) begin
        s_vld[s] = 1'b1;
        s_dat[s] = DW'($urandom);
      end
      tick("R2");
    end

    // R6: random partial traffic with shared destinations
    for (int i = 0; i < 250; i++) begin
      for (int s = 0; s < N; s++) begin
        s_vld[s] = ($urandom % 2) == 1;
        s_dst[s] = AW'($urandom);
        s_dat[s] = DW'($urandom);
      end
      tick("R6");
    end

    clear_set();
    for (int i = 0; i <= NLOG; i++) tick("R8");
    finish_run();
  end

endmodule